// File: doc/BRIEF.md
# Page-Mode DRAM Wait-State Sequencer

This block runs the memory cycle for a CPU attached to page-mode DRAM split over two banks. Each bank keeps one row open between accesses. Every accepted request is classed as a page hit or a page miss against the open row of the bank it addresses. A hit runs only a column phase. A miss first precharges the bank by releasing its row strobe, then opens the new row, and only then runs the column phase. Wait states are inserted during the column phase before ready is returned. Hits use fixed counts, while misses and the very first access to a bank use counts that software programs.

Configuration is written through a two-port window. A write with the select input low loads a register index. A write with the select input high stores data into the register named by that index. A mode register enables page operation. It also enables the interleaved map, which takes effect only when a second flag reports that both banks are fitted. With the interleaved map the lowest row-select bit picks the bank, so one logical page spans both banks and stepping across the half-page boundary reaches a row that is already open.

Top module: `pgdram_waitseq`

## Requirements
- R1: A read that hits the open row of its bank inserts no wait states. Ready rises on the 1st rising edge after the edge that accepts the request.
- R2: A write that hits the open row inserts exactly one wait state. Ready rises on the 2nd rising edge after acceptance.
- R3: A miss on a bank that has been opened before drives that bank's row strobe high for one precharge cycle, then drives the row address with the strobe low, then runs the column phase with the programmed miss count W. Ready rises on edge 3+W after acceptance. The miss count resets to 4.
- R4: The first access to each bank after reset is a miss that uses the first-cycle count F instead of W, so ready rises on edge 3+F. F resets to 3.
- R5: The configuration window has three registers. Index 1 is the mode register. Index 2 holds F[2:1] in data bits 7:6 and W[2:1] in data bits 5:4. Index 3 holds F[0] in data bit 3 and W[0] in data bit 4. A data write under any other index changes nothing.
- R6: Ready is high for exactly one clock. A request is taken only while the sequencer is idle, which is the cycle after the ready pulse at the earliest. A held request is therefore serviced again one clock after ready.
- R7: With mode bit 0 (page enable) cleared, every access runs as a miss. Mode resets to 0x05.
- R8: With mode bit 1 (interleave) and bit 2 (both banks fitted) both set, the bank is address bit COL_W and the row is the bits above it. Otherwise the bank is the top address bit and the row is the ROW_W bits above the column.
- R9: Every data write to the mode register closes both open rows. Rows opened before the write give misses afterwards.
- R10: After reset all strobes are high and ready is low. A bank's row strobe is low while its row is open. The column strobe is low only during the column phase, which drives the column address. The write strobe is low only during the column phase of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | COL_W+ROW_W+1 | Word address |
| cpu_ready | output | 1 | One-clock completion pulse |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = index port, 1 = data port |
| cfg_wdata | input | 8 | Configuration write data |
| dram_ras_n | output | 2 | Row strobe per bank, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |

## Verification
The bench builds the sequencer with COL_W=4 and ROW_W=4. This gives a 9-bit address whose bank, row and column fields can be written out by hand for both address maps. It also lets the bench pick addresses that fall in different banks under the two maps. The small fields and the 3-bit wait counts keep the longest miss latency short. Every programmed count can therefore be timed exactly, cycle by cycle, against the fixed hit latencies.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   localparam int WAIT_W = 3;
   localparam int NBANK  = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_ROW,
      ST_COL,
      ST_DONE
   } cyc_state_t;
endpackage

// File: rtl/pgw_cfg.sv
module pgw_cfg
   import pgw_pkg::*;
#(
   parameter logic [7:0] IDX_MODE = 8'h01,
   parameter logic [7:0] IDX_WHI  = 8'h02,
   parameter logic [7:0] IDX_WLO  = 8'h03,
   parameter logic [2:0] MODE_RST = 3'b101,
   parameter int         FIRST_RST = 3,
   parameter int         MISS_RST  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_sel,
   input  logic [7:0]        cfg_wdata,
   output logic              page_en,
   output logic              enh_en,
   output logic              mode_wr,
   output logic [WAIT_W-1:0] first_ws,
   output logic [WAIT_W-1:0] miss_ws
);
   localparam logic [2:0] FR = FIRST_RST[2:0];
   localparam logic [2:0] MR = MISS_RST[2:0];

   logic [7:0] idx_q;
   logic [2:0] mode_q;
   logic [3:0] whi_q;
   logic [1:0] wlo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         mode_q <= MODE_RST;
         whi_q  <= {FR[2:1], MR[2:1]};
         wlo_q  <= {MR[0], FR[0]};
      end else if (cfg_wr) begin
         if (!cfg_sel) begin
            idx_q <= cfg_wdata;
         end else begin
            case (idx_q)
               IDX_MODE: mode_q <= cfg_wdata[2:0];
               IDX_WHI:  whi_q  <= cfg_wdata[7:4];
               IDX_WLO:  wlo_q  <= cfg_wdata[4:3];
               default:  ;
            endcase
         end
      end
   end

   assign mode_wr  = cfg_wr && cfg_sel && (idx_q == IDX_MODE);
   assign page_en  = mode_q[0];
   assign enh_en   = mode_q[1] && mode_q[2];
   assign first_ws = {whi_q[3:2], wlo_q[0]};
   assign miss_ws  = {whi_q[1:0], wlo_q[1]};

   a_r9_mode_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> (page_en == $past(cfg_wdata[0])));
endmodule

// File: rtl/pgw_map.sv
module pgw_map #(
   parameter int COL_W = 8,
   parameter int ROW_W = 8,
   localparam int ADDR_W = COL_W + ROW_W + 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              enh,
   output logic              bank,
   output logic [ROW_W-1:0]  row,
   output logic [COL_W-1:0]  col
);
   assign col = addr[COL_W-1:0];

   always_comb begin
      if (enh) begin
         bank = addr[COL_W];
         row  = addr[COL_W+1 +: ROW_W];
      end else begin
         bank = addr[ADDR_W-1];
         row  = addr[COL_W +: ROW_W];
      end
   end
endmodule

// File: rtl/pgw_rows.sv
module pgw_rows
   import pgw_pkg::*;
#(
   parameter int ROW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             look_bank,
   input  logic [ROW_W-1:0] look_row,
   input  logic             close_stb,
   input  logic             open_stb,
   input  logic             open_bank,
   input  logic [ROW_W-1:0] open_row,
   output logic             hit,
   output logic             first,
   output logic [NBANK-1:0] ras_n
);
   logic [NBANK-1:0]            valid_q;
   logic [NBANK-1:0]            used_q;
   logic [NBANK-1:0][ROW_W-1:0] tag_q;
   logic [NBANK-1:0]            bank_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         used_q  <= '0;
         tag_q   <= '0;
      end else begin
         for (int b = 0; b < NBANK; b++) begin
            if (flush) begin
               valid_q[b] <= 1'b0;
            end else if (close_stb && look_bank == b[0]) begin
               valid_q[b] <= 1'b0;
            end else if (open_stb && open_bank == b[0]) begin
               valid_q[b] <= 1'b1;
               used_q[b]  <= 1'b1;
               tag_q[b]   <= open_row;
            end
         end
      end
   end

   for (genvar g = 0; g < NBANK; g++) begin : g_cmp
      assign bank_hit[g] = valid_q[g] && (tag_q[g] == look_row);
   end

   assign hit   = bank_hit[look_bank];
   assign first = !used_q[look_bank];
   assign ras_n = ~valid_q;

   a_r9_flush_closes: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (ras_n == '1));
endmodule

// File: rtl/pgdram_waitseq.sv
module pgdram_waitseq
   import pgw_pkg::*;
#(
   parameter int COL_W     = 8,
   parameter int ROW_W     = 8,
   parameter int FIRST_RST = 3,
   parameter int MISS_RST  = 4,
   localparam int ADDR_W = COL_W + ROW_W + 1,
   localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_ready,
   input  logic              cfg_wr,
   input  logic              cfg_sel,
   input  logic [7:0]        cfg_wdata,
   output logic [1:0]        dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic [MA_W-1:0]   dram_addr
);
   if (COL_W < 1 || ROW_W < 1) begin : g_bad_width
      $error("pgdram_waitseq: COL_W and ROW_W must be at least 1");
   end
   if (FIRST_RST < 0 || FIRST_RST >= (1 << WAIT_W) ||
       MISS_RST < 0 || MISS_RST >= (1 << WAIT_W)) begin : g_bad_wait
      $error("pgdram_waitseq: reset wait counts exceed the wait field");
   end

   logic              page_en, enh_en, mode_wr;
   logic [WAIT_W-1:0] first_ws, miss_ws;
   logic              map_bank;
   logic [ROW_W-1:0]  map_row;
   logic [COL_W-1:0]  map_col;
   logic              trk_hit, trk_first;
   logic              acc_hit, accept, close_stb, open_stb;

   cyc_state_t        state_q;
   logic [WAIT_W-1:0] cnt_q;
   logic              cur_bank, cur_we;
   logic [ROW_W-1:0]  cur_row;
   logic [COL_W-1:0]  cur_col;

   pgw_cfg #(.FIRST_RST(FIRST_RST), .MISS_RST(MISS_RST)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .page_en(page_en), .enh_en(enh_en),
      .mode_wr(mode_wr), .first_ws(first_ws), .miss_ws(miss_ws)
   );

   pgw_map #(.COL_W(COL_W), .ROW_W(ROW_W)) u_map (
      .addr(cpu_addr), .enh(enh_en),
      .bank(map_bank), .row(map_row), .col(map_col)
   );

   pgw_rows #(.ROW_W(ROW_W)) u_rows (
      .clk(clk), .rst_n(rst_n), .flush(mode_wr),
      .look_bank(map_bank), .look_row(map_row),
      .close_stb(close_stb), .open_stb(open_stb),
      .open_bank(cur_bank), .open_row(cur_row),
      .hit(trk_hit), .first(trk_first), .ras_n(dram_ras_n)
   );

   assign accept    = (state_q == ST_IDLE) && cpu_req;
   assign acc_hit   = page_en && trk_hit;
   assign close_stb = accept && !acc_hit;
   assign open_stb  = (state_q == ST_PRE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         cur_bank <= 1'b0;
         cur_we   <= 1'b0;
         cur_row  <= '0;
         cur_col  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (cpu_req) begin
               cur_bank <= map_bank;
               cur_row  <= map_row;
               cur_col  <= map_col;
               cur_we   <= cpu_we;
               if (acc_hit) begin
                  state_q <= ST_COL;
                  cnt_q   <= cpu_we ? WAIT_W'(1) : '0;
               end else begin
                  state_q <= ST_PRE;
                  cnt_q   <= trk_first ? first_ws : miss_ws;
               end
            end
            ST_PRE:  state_q <= ST_ROW;
            ST_ROW:  state_q <= ST_COL;
            ST_COL:  if (cnt_q == '0) state_q <= ST_DONE;
                     else cnt_q <= cnt_q - 1'b1;
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_ready  = (state_q == ST_DONE);
   assign dram_cas_n = !(state_q == ST_COL);
   assign dram_we_n  = !((state_q == ST_COL) && cur_we);
   assign dram_addr  = (state_q == ST_COL) ? MA_W'(cur_col) : MA_W'(cur_row);

   a_r6_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready);
   a_r1_hit_read_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && acc_hit && !cpu_we) |-> ##2 cpu_ready);
   a_r2_hit_write_one_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && acc_hit && cpu_we) |-> ##2 !cpu_ready ##1 cpu_ready);
   a_r3_precharge_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PRE) |-> dram_ras_n[cur_bank]);
   a_r10_cas_inside_row: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !dram_ras_n[cur_bank]);
endmodule

// File: tb/pgdram_waitseq_test.sv
module pgdram_waitseq_test;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 4;
   localparam int RW = 4;
   localparam int AW = CW + RW + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic          cpu_ready;
   logic          cfg_wr = 1'b0, cfg_sel = 1'b0;
   logic [7:0]    cfg_wdata = '0;
   logic [1:0]    dram_ras_n;
   logic          dram_cas_n, dram_we_n;
   logic [3:0]    dram_addr;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   logic [1:0] ras_seen_hi;
   logic [3:0] col_seen;
   bit         we_seen;

   pgdram_waitseq #(.COL_W(CW), .ROW_W(RW)) uut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .cfg_wr(cfg_wr),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .dram_ras_n(dram_ras_n),
      .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_addr(dram_addr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [AW-1:0] na(input bit b, input int r, input int c);
      return {b, 4'(r), 4'(c)};
   endfunction
   function automatic logic [AW-1:0] ea(input bit b, input int r, input int c);
      return {4'(r), b, 4'(c)};
   endfunction

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] idx, input logic [7:0] dat);
      cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = idx;
      @(negedge clk);
      cfg_sel = 1'b1; cfg_wdata = dat;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_sel = 1'b0;
   endtask

   task automatic access(input logic [AW-1:0] a, input bit w, input int exp,
                         input string rq);
      int n = 0;
      ras_seen_hi = '0; we_seen = 1'b0; col_seen = '0;
      cpu_addr = a; cpu_we = w; cpu_req = 1'b1;
      do begin
         @(negedge clk);
         n++;
         ras_seen_hi |= dram_ras_n;
         if (!dram_cas_n) begin
            col_seen = dram_addr;
            if (!dram_we_n) we_seen = 1'b1;
         end
      end while (!cpu_ready && n < 40);
      cpu_req = 1'b0;
      chk(n == exp, rq, n, exp);
      @(negedge clk);
      chk(cpu_ready == 1'b0, "R6 ready one clock", cpu_ready, 0);
   endtask

   task automatic t_reset();
      chk(cpu_ready == 1'b0 && dram_cas_n && dram_we_n, "R10 reset outputs", cpu_ready, 0);
      chk(dram_ras_n == 2'b11, "R10 reset row strobes", dram_ras_n, 3);
   endtask

   task automatic t_first_and_hits();
      access(na(0, 2, 5), 1'b0, 7, "R4 first access reset count");
      chk(dram_ras_n[0] == 1'b0, "R10 bank0 row held open", dram_ras_n[0], 0);
      chk(col_seen == 4'd5, "R10 column address", col_seen, 5);
      access(na(0, 2, 9), 1'b0, 2, "R1 hit read latency");
      chk(col_seen == 4'd9, "R10 column on hit", col_seen, 9);
      access(na(0, 2, 1), 1'b1, 3, "R2 hit write latency");
      chk(we_seen, "R10 write strobe on write", we_seen, 1);
   endtask

   task automatic t_miss_default();
      access(na(0, 6, 0), 1'b0, 8, "R3 miss reset count");
      chk(ras_seen_hi[0], "R3 precharge seen", ras_seen_hi[0], 1);
      chk(!we_seen, "R10 no write strobe on read", we_seen, 0);
   endtask

   task automatic t_program();
      cfg_write(8'h02, 8'h20);
      cfg_write(8'h03, 8'h18);
      access(na(1, 3, 0), 1'b0, 5, "R5 R4 programmed first count");
      access(na(0, 2, 0), 1'b0, 9, "R5 R3 programmed miss count");
      cfg_write(8'h09, 8'h00);
      access(na(0, 7, 0), 1'b0, 9, "R5 unknown index ignored");
   endtask

   task automatic t_held_request();
      int n = 0;
      cpu_addr = na(0, 7, 1); cpu_we = 1'b0; cpu_req = 1'b1;
      do begin @(negedge clk); n++; end while (!cpu_ready && n < 40);
      chk(n == 2, "R6 held request first service", n, 2);
      n = 0;
      do begin
         @(negedge clk); n++;
         if (n == 1) chk(cpu_ready == 1'b0, "R6 gap after ready", cpu_ready, 0);
      end while (!cpu_ready && n < 40);
      cpu_req = 1'b0;
      chk(n == 3, "R6 held request re-accepted", n, 3);
      @(negedge clk);
   endtask

   task automatic t_page_off();
      cfg_write(8'h01, 8'h04);
      access(na(0, 7, 2), 1'b0, 9, "R7 page off miss");
      access(na(0, 7, 2), 1'b0, 9, "R7 page off repeat still miss");
   endtask

   task automatic t_interleave();
      cfg_write(8'h01, 8'h07);
      access(ea(0, 3, 0), 1'b0, 9, "R8 interleave bank0 open");
      access(ea(1, 3, 0), 1'b0, 9, "R8 interleave bank1 open");
      access(ea(0, 3, 4), 1'b0, 2, "R8 interleave bank0 hit");
      access(ea(1, 3, 4), 1'b0, 2, "R8 interleave bank1 hit");
      chk(dram_ras_n == 2'b00, "R8 both banks open", dram_ras_n, 0);
      cfg_write(8'h01, 8'h07);
      access(ea(0, 3, 4), 1'b0, 9, "R9 mode write closes rows");
      cfg_write(8'h01, 8'h03);
      access(ea(1, 3, 0), 1'b0, 9, "R8 no second bank normal map");
      chk(dram_ras_n == 2'b10, "R8 normal map picks bank0", dram_ras_n, 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_and_hits();
      t_miss_default();
      t_program();
      t_held_request();
      t_page_off();
      t_interleave();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule